// File: doc/BRIEF.md
# Four-Lane Receive Column Deskew

This block lines up four decoded receive lanes so that bytes sent in one column leave it in one output beat. Each lane runs through a short history window. While the block is hunting, it records how many beats ago each lane last showed the alignment character, which is byte 0x7C with its K-flag set. Once every lane has shown one inside the window, it sets a per-lane read tap so that those characters come out together.

After that, the taps are frozen. A hysteresis machine then watches the alignment characters as they leave the taps. It needs three more full columns before it declares lock. Once locked, it lets isolated partial columns slip past before it gives up and hunts again. While it is not locked, the output carries a fixed local-fault word in place of lane data.

Data moves as one valid/ready stream of four-lane beats, with one output register. An input beat is taken when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained this cycle, so back-pressure on `out_ready` stalls the input at once. A held output beat stays unchanged until it is taken. Per-lane sync status and the `aligned` flag are plain level signals.

Top module: `lane_deskew`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. Every accepted input beat gives exactly one output beat on the next clock. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_k` hold.
- R2: After reset the machine is hunting and `aligned`, `out_valid` are 0. If any bit of `lane_sync` is 0 in a cycle, the machine is hunting in the next cycle, whatever its state.
- R3: The alignment character is data 0x7C with K=1. While hunting, when every lane has shown one within the last DEPTH-1 accepted beats, each lane's tap is set to the age of that character, and the machine moves to the first confirm state.
- R4: Lane taps change only while hunting. In every other state they hold, although alignment characters are still detected at the taps.
- R5: In the three confirm states, a full column (all four taps show the alignment character in one beat) advances the machine one step. After the third step it is locked. A partial column (some taps, but not all, show it) sends the machine back to hunting.
- R6: `aligned` is 1 in the locked state and the three miss states, and 0 in hunting and the confirm states.
- R7: When locked, a partial column moves to miss-1. In miss-1 a full column returns to locked and a partial column moves to miss-2. In miss-2 a full column moves to miss-1 and a partial column moves to miss-3. In miss-3 a full column moves to miss-2 and a partial column moves to hunting.
- R8: A beat accepted while `aligned` is 1 leaves with each lane's byte and K-flag taken from that lane's tap, lane n in bits [8n+7:8n] of the data and bit n of the K vector.
- R9: A beat accepted while `aligned` is 0 leaves as the fault word: lane 0 carries 0x9C with K=1, lanes 1 and 2 carry 0x00, lane 3 carries 0x01, and lanes 1 to 3 have K=0.
- R10: If a lane's recorded character has aged DEPTH-1 beats and the column is still incomplete, all records are dropped and the search restarts. No tap is ever set from a character older than the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat can be taken |
| in_data | input | LANES*8 | Decoded byte per lane, lane 0 in the low byte |
| in_k | input | LANES | K-flag per lane |
| lane_sync | input | LANES | Code-group sync status per lane, 1 = in sync |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream takes the output beat |
| out_data | output | LANES*8 | Deskewed bytes, or the fault word |
| out_k | output | LANES | K-flags matching out_data |
| aligned | output | 1 | Column lock status |

## Verification
The bench feeds lanes with distinct skews, including the largest skew the window can correct. It checks that every output column after lock matches the reference stream delayed by the largest skew; a tap built from the wrong age would shift one lane by a beat.

It removes the alignment character from one lane at chosen periods. This walks the machine through a confirm abort and up and down the miss states until it falls back. A design with an off-by-one in the hysteresis would raise or drop `aligned` a period early or late.

One scenario shows a lone character on one lane, far ahead of the others. A design without the age-out restart would build taps from a stale record and lock one period late. A sync drop while locked, and steady back-pressure, check the forced return to hunting and the stall-hold rule.

// File: rtl/lane_deskew_pkg.sv
package lane_deskew_pkg;

  typedef enum logic [2:0] {
    ST_HUNT  = 3'd0,
    ST_CHK1  = 3'd1,
    ST_CHK2  = 3'd2,
    ST_CHK3  = 3'd3,
    ST_LOCK  = 3'd4,
    ST_MISS1 = 3'd5,
    ST_MISS2 = 3'd6,
    ST_MISS3 = 3'd7
  } col_state_e;

  localparam logic [7:0] MARK_BYTE  = 8'h7C;
  localparam logic [7:0] FAULT_BYTE = 8'h9C;
  localparam logic [7:0] FAULT_TAIL = 8'h01;

  function automatic logic is_mark(input logic [7:0] byte_v, input logic k_v);
    return k_v && (byte_v == MARK_BYTE);
  endfunction

endpackage

// File: rtl/lane_deskew_lane.sv
module lane_deskew_lane #(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic       hunt,
  input  logic       clear,
  input  logic       load,
  input  logic [7:0] in_byte,
  input  logic       in_k,
  output logic       mark_now,
  output logic       found,
  output logic       over,
  output logic       mark_tap,
  output logic [7:0] tap_byte,
  output logic       tap_k
);
  import lane_deskew_pkg::*;

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] AGE_MAX = AW'(DEPTH - 1);

  logic [7:0]    hist_b [DEPTH-1];
  logic          hist_k [DEPTH-1];
  logic [7:0]    win_b  [DEPTH];
  logic          win_k  [DEPTH];
  logic [AW-1:0] tap_q;
  logic [AW-1:0] age_q;
  logic          found_q;

  // window index 0 is the live input, index i is i accepted beats back
  assign win_b[0] = in_byte;
  assign win_k[0] = in_k;
  for (genvar i = 1; i < DEPTH; i++) begin : g_win
    assign win_b[i] = hist_b[i-1];
    assign win_k[i] = hist_k[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH-1; i++) begin
        hist_b[i] <= '0;
        hist_k[i] <= 1'b0;
      end
    end else if (fire) begin
      hist_b[0] <= in_byte;
      hist_k[0] <= in_k;
      for (int i = 1; i < DEPTH-1; i++) begin
        hist_b[i] <= hist_b[i-1];
        hist_k[i] <= hist_k[i-1];
      end
    end
  end

  assign mark_now = is_mark(in_byte, in_k);
  assign found    = found_q;
  assign over     = found_q && (age_q == AGE_MAX);

  // search record: age_q is the window index of the recorded mark
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found_q <= 1'b0;
      age_q   <= '0;
      tap_q   <= '0;
    end else if (load) begin
      tap_q   <= found_q ? age_q : '0;
      found_q <= 1'b0;
    end else if (clear) begin
      found_q <= 1'b0;
    end else if (fire && hunt) begin
      if (found_q) begin
        age_q <= age_q + AW'(1);
      end else if (mark_now) begin
        found_q <= 1'b1;
        age_q   <= AW'(1);
      end
    end
  end

  assign tap_byte = win_b[tap_q];
  assign tap_k    = win_k[tap_q];
  assign mark_tap = is_mark(tap_byte, tap_k);

  AST_TAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !hunt |=> $stable(tap_q)); // R4

endmodule

// File: rtl/lane_deskew_fsm.sv
module lane_deskew_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic sync_all,
  input  logic all_here,
  input  logic col_full,
  input  logic col_part,
  output logic hunt,
  output logic locked
);
  import lane_deskew_pkg::*;

  col_state_e state_q;
  col_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (!sync_all) begin
      state_d = ST_HUNT;
    end else if (fire) begin
      unique case (state_q)
        ST_HUNT:  if (all_here) state_d = ST_CHK1;
        ST_CHK1:  if (col_full) state_d = ST_CHK2;  else if (col_part) state_d = ST_HUNT;
        ST_CHK2:  if (col_full) state_d = ST_CHK3;  else if (col_part) state_d = ST_HUNT;
        ST_CHK3:  if (col_full) state_d = ST_LOCK;  else if (col_part) state_d = ST_HUNT;
        ST_LOCK:  if (col_part) state_d = ST_MISS1;
        ST_MISS1: if (col_full) state_d = ST_LOCK;  else if (col_part) state_d = ST_MISS2;
        ST_MISS2: if (col_full) state_d = ST_MISS1; else if (col_part) state_d = ST_MISS3;
        ST_MISS3: if (col_full) state_d = ST_MISS2; else if (col_part) state_d = ST_HUNT;
        default:  state_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_HUNT;
    else        state_q <= state_d;
  end

  assign hunt   = (state_q == ST_HUNT);
  assign locked = state_q inside {ST_LOCK, ST_MISS1, ST_MISS2, ST_MISS3};

  AST_SYNC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_all |=> state_q == ST_HUNT); // R2
  AST_HUNT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sync_all && all_here && state_q == ST_HUNT) |=> state_q == ST_CHK1); // R3
  AST_CHK_PROMOTE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sync_all && col_full && state_q == ST_CHK3) |=> state_q == ST_LOCK); // R5
  AST_CHK_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sync_all && col_part && state_q inside {ST_CHK1, ST_CHK2, ST_CHK3})
    |=> state_q == ST_HUNT); // R5
  AST_FLAG_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> state_q == ST_HUNT); // R6
  AST_LOCK_SLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sync_all && col_part && state_q == ST_LOCK) |=> state_q == ST_MISS1); // R7
  AST_MISS_GIVEUP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sync_all && col_part && state_q == ST_MISS3) |=> state_q == ST_HUNT); // R7

endmodule

// File: rtl/lane_deskew_out.sv
module lane_deskew_out #(
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               out_ready,
  input  logic               locked,
  input  logic [LANES*8-1:0] tap_data,
  input  logic [LANES-1:0]   tap_k,
  output logic               in_ready,
  output logic               fire,
  output logic               out_valid,
  output logic [LANES*8-1:0] out_data,
  output logic [LANES-1:0]   out_k
);
  import lane_deskew_pkg::*;

  logic [LANES*8-1:0] fault_data;
  logic [LANES-1:0]   fault_k;

  for (genvar g = 0; g < LANES; g++) begin : g_fault
    if (g == 0) begin : g_head
      assign fault_data[7:0] = FAULT_BYTE;
      assign fault_k[0]      = 1'b1;
    end else if (g == LANES-1) begin : g_tail
      assign fault_data[g*8 +: 8] = FAULT_TAIL;
      assign fault_k[g]           = 1'b0;
    end else begin : g_mid
      assign fault_data[g*8 +: 8] = 8'h00;
      assign fault_k[g]           = 1'b0;
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_k     <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_data  <= locked ? tap_data : fault_data;
      out_k     <= locked ? tap_k    : fault_k;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_k))); // R1
  AST_PASS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && locked) |=> (out_data == $past(tap_data) && out_k == $past(tap_k))); // R8
  AST_FAULT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !locked) |=> (out_data == fault_data && out_k == fault_k)); // R9

endmodule

// File: rtl/lane_deskew.sv
module lane_deskew #(
  parameter int LANES = 4,
  parameter int DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [LANES*8-1:0] in_data,
  input  logic [LANES-1:0]   in_k,
  input  logic [LANES-1:0]   lane_sync,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [LANES*8-1:0] out_data,
  output logic [LANES-1:0]   out_k,
  output logic               aligned
);
  logic               fire, hunt, locked, sync_all;
  logic               all_here, col_full, col_part, any_over;
  logic               restart, load, clear;
  logic [LANES-1:0]   mark_now, found, over, mark_tap, tap_k;
  logic [LANES*8-1:0] tap_data;

  assign sync_all = &lane_sync;
  assign all_here = &(found | mark_now);
  assign any_over = |over;
  assign col_full = &mark_tap;
  assign col_part = (|mark_tap) && !col_full;
  assign load     = fire && hunt && sync_all && all_here;
  assign restart  = fire && hunt && sync_all && !all_here && any_over;
  assign clear    = restart || !hunt || !sync_all;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_deskew_lane #(.DEPTH(DEPTH)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (fire),
      .hunt     (hunt),
      .clear    (clear),
      .load     (load),
      .in_byte  (in_data[g*8 +: 8]),
      .in_k     (in_k[g]),
      .mark_now (mark_now[g]),
      .found    (found[g]),
      .over     (over[g]),
      .mark_tap (mark_tap[g]),
      .tap_byte (tap_data[g*8 +: 8]),
      .tap_k    (tap_k[g])
    );
  end

  lane_deskew_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .sync_all (sync_all),
    .all_here (all_here),
    .col_full (col_full),
    .col_part (col_part),
    .hunt     (hunt),
    .locked   (locked)
  );

  lane_deskew_out #(.LANES(LANES)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .locked    (locked),
    .tap_data  (tap_data),
    .tap_k     (tap_k),
    .in_ready  (in_ready),
    .fire      (fire),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_k     (out_k)
  );

  assign aligned = locked;

  AST_AGE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> found == '0); // R10

endmodule

// File: tb/lane_deskew_tb_top.sv
`timescale 1ns/1ps
module lane_deskew_tb_top;
  localparam int LANES = 4;
  localparam int DEPTH = 8;
  localparam logic [35:0] FAULT_WORD = {4'b0001, 8'h01, 8'h00, 8'h00, 8'h9C};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic [LANES*8-1:0] in_data = '0;
  logic [LANES-1:0]   in_k = '0;
  logic [LANES-1:0]   lane_sync = '1;
  logic               out_valid;
  logic               out_ready = 1'b1;
  logic [LANES*8-1:0] out_data;
  logic [LANES-1:0]   out_k;
  logic               aligned;

  lane_deskew #(.LANES(LANES), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_k(in_k), .lane_sync(lane_sync),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_k(out_k), .aligned(aligned)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [35:0] sb_q[$];
  int skew[LANES];
  int scen = 0;
  int reg_start = 8;
  int b = 0;
  int ref_st = 0;
  logic [63:0] drop_per = '0;
  string last_tag = "R2";
  logic held_v = 1'b0;
  logic [35:0] held_w = '0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // reference lane stream: {k, byte}
  function automatic logic [8:0] gen(int n, int l);
    if (n < 0) return {1'b0, 8'h11};
    if (n >= reg_start && (n % 16) == 8 && !(l == 2 && drop_per[(n / 16) % 64]))
      return {1'b1, 8'h7C};
    if (scen == 2 && ((l == 0 && n == 8) || (l != 0 && n == 17)))
      return {1'b1, 8'h7C};
    return {1'b0, 8'((n * 7 + l * 29 + 5) % 256)};
  endfunction

  function automatic bit reg_mark(int n);
    return n >= reg_start && (n % 16) == 8 && !drop_per[(n / 16) % 64];
  endfunction

  function automatic int max_skew();
    int m = 0;
    for (int l = 0; l < LANES; l++) if (skew[l] > m) m = skew[l];
    return m;
  endfunction

  task automatic fail(string tag, string what, logic [35:0] act, logic [35:0] exp);
    errors++;
    $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
  endtask

  // driver side of the scoreboard: expected word and reference machine step
  task automatic model_beat();
    int ms = max_skew();
    logic [35:0] exp_w;
    logic [8:0] v;
    int cnt = 0;
    if (ref_st >= 4) begin
      for (int l = 0; l < LANES; l++) begin
        v = gen(b - ms, l);
        exp_w[l*8 +: 8] = v[7:0];
        exp_w[32 + l]   = v[8];
      end
    end else begin
      exp_w = FAULT_WORD;
    end
    sb_q.push_back(exp_w);
    if (ref_st == 0) begin
      last_tag = (ms > DEPTH - 1) ? "R10" : "R3";
      if (ms <= DEPTH - 1 && reg_mark(b - ms)) ref_st = 1;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        v = gen(b - ms, l);
        if (v == {1'b1, 8'h7C}) cnt++;
      end
      if (ref_st <= 3) begin
        last_tag = "R5";
        if (cnt == LANES) ref_st++;
        else if (cnt > 0) ref_st = 0;
      end else begin
        last_tag = "R7";
        case (ref_st)
          4: if (cnt > 0 && cnt < LANES) ref_st = 5;
          5: if (cnt == LANES) ref_st = 4; else if (cnt > 0) ref_st = 6;
          6: if (cnt == LANES) ref_st = 5; else if (cnt > 0) ref_st = 7;
          7: if (cnt == LANES) ref_st = 6; else if (cnt > 0) ref_st = 0;
          default: ref_st = 0;
        endcase
      end
    end
    b++;
  endtask

  task automatic drive_inputs();
    logic [8:0] v;
    for (int l = 0; l < LANES; l++) begin
      v = gen(b - skew[l], l);
      in_data[l*8 +: 8] = v[7:0];
      in_k[l] = v[8];
    end
  endtask

  task automatic run_beats(int nbeats);
    int done = 0;
    while (done < nbeats) begin
      @(negedge clk);
      out_ready = (cyc % 5) != 3;
      in_valid  = (cyc % 7) != 6;
      drive_inputs();
      #1;
      if (in_valid && in_ready) begin
        checks++; // R6 flag against the reference machine
        if (aligned !== (ref_st >= 4))
          fail({"R6 after ", last_tag}, "aligned flag", 36'(aligned), 36'(ref_st >= 4));
        model_beat();
        done++;
      end
    end
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    for (int i = 0; i < 40 && sb_q.size() != 0; i++) @(negedge clk);
    checks++;
    if (sb_q.size() != 0) fail("R1", "undelivered beats", 36'(sb_q.size()), 36'd0);
  endtask

  task automatic start(int s, int s0, int s1, int s2, int s3, int rs, logic [63:0] drops);
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    lane_sync = '1;
    out_ready = 1'b1;
    scen = s; reg_start = rs; drop_per = drops;
    skew[0] = s0; skew[1] = s1; skew[2] = s2; skew[3] = s3;
    b = 0; ref_st = 0; last_tag = "R2";
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    checks++; // R2 reset state
    if (aligned !== 1'b0 || out_valid !== 1'b0 || in_ready !== 1'b1)
      fail("R2", "reset state {aligned,out_valid,in_ready}",
           36'({aligned, out_valid, in_ready}), 36'(3'b001));
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    #2;
    if (!rst_n) begin
      held_v = 1'b0;
    end else begin
      if (held_v) begin
        checks++; // R1 stall hold
        if (!out_valid || {out_k, out_data} !== held_w)
          fail("R1", "held beat changed", {out_k, out_data}, held_w);
        held_v = 1'b0;
      end
      if (out_valid) begin
        if (out_ready) begin
          checks++;
          if (sb_q.size() == 0) begin
            fail("R1", "unexpected output beat", {out_k, out_data}, '0);
          end else begin
            logic [35:0] e;
            e = sb_q.pop_front();
            if ({out_k, out_data} !== e)
              fail((e == FAULT_WORD) ? "R9" : "R8", "output column", {out_k, out_data}, e);
          end
        end else begin
          held_v = 1'b1;
          held_w = {out_k, out_data};
        end
      end
    end
  end

  initial begin
    // A: skews 3,0,5,1; lane 2 loses its mark in chosen periods (R5, R7, R4, R8)
    start(0, 3, 0, 5, 1, 8,
          (64'd1 << 1) | (64'd1 << 6) | (64'd1 << 8) | (64'd1 << 9) |
          (64'd1 << 11) | (64'd1 << 12) | (64'd1 << 14) | (64'd1 << 15));
    run_beats(300);
    drain();

    // B: widest correctable skew, then a sync drop while locked (R3, R2)
    start(1, 0, 7, 2, 4, 8, '0);
    run_beats(100);
    while ((b % 16) != 0) run_beats(1);
    @(negedge clk);
    in_valid = 1'b0;
    lane_sync = 4'b1011;
    @(negedge clk);
    lane_sync = '1;
    ref_st = 0;
    last_tag = "R2";
    #1;
    checks++; // R2 sync loss forces hunting
    if (aligned !== 1'b0) fail("R2", "aligned after sync loss", 36'(aligned), 36'd0);
    run_beats(100);
    drain();

    // C: stale lone mark on lane 0 must age out before the regular marks (R10)
    start(2, 0, 0, 0, 0, 40, '0);
    run_beats(140);
    drain();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R1 watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule